// File: doc/BRIEF.md
# Masked clock gate and reset controller

This block is a memory-mapped control unit that switches a set of module clock enables on and off and drives a set of module reset lines. Software reaches it through a simple register bus made of an address, write data, a write strobe and registered read data. Control state is held in 32-bit words. The low half of a word carries 16 control bits. The high half carries one write-enable bit per control bit, so a single write can change any subset of bits without a read-modify-write sequence.

Each control word has a read-only monitor word beside it. The monitor word reports the state that has actually reached the clock gates or reset lines. It follows the control state after a programmable settle delay, which stands in for the gate and reset propagation time. Software writes a control word and polls the matching monitor word until the new state shows. A clock or reset identifier `id` selects control word `id / 16`, bit `id % 16`.

Top module: `modgate_ctrl`

## Requirements
- R1: After the synchronous reset, every clock enable is 0, every reset output is 1, clock monitor words read 0, reset monitor words read 0x0000FFFF and reset control words read 0.
- R2: A write to a control word changes bit k (0..15) only when bit k+16 of the write data is 1; bits whose enable is 0 keep their value.
- R3: A write to clock control word n at address 0x600 + 4n sets each enabled bit to the data bit: 1 turns that clock enable on and 0 turns it off, visible on `clk_en_o` one cycle after the write.
- R4: A write to reset control word n at address 0x900 + 4n asserts reset for each enabled bit whose data bit is 0 and releases it for each enabled bit whose data bit is 1, visible on `rst_o` (1 = reset in effect) one cycle after the write.
- R5: Clock monitor word n at address 0xA00 - 0x200 + 4n (that is 0x800 + 4n) reports each clock enable exactly SETTLE cycles after it changes, 1 meaning the clock is running.
- R6: Reset monitor word n at 0xA00 + 4n reports each reset output exactly SETTLE cycles after it changes, 1 while reset is in effect and 0 once released.
- R7: A read returns its data one cycle after the address is presented. A clock control word reads back its enables and a reset control word reads back 1 for each released line. Bits 31..16 of a control word read as 0.
- R8: Writes to monitor addresses, to unmapped addresses and to addresses whose two low bits are not 0 change no output and no monitor state.
- R9: Identifier id corresponds to control word id / 16, bit id % 16, and drives bit id of `clk_en_o` or `rst_o`.
- R10: Reads from an unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data: enables in 31..16, values in 15..0 |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| clk_en_o | output | 16*NUM_WORDS | Clock enable per module clock, 1 = running |
| rst_o | output | 16*NUM_WORDS | Reset per module, 1 = held in reset |

## Verification
Every cycle the assertions check the per-bit mask rule for clock and reset writes, the value an enabled bit takes, that outputs hold when no write arrives or when a monitor address is written, that control words read 0 in their upper half, and that each monitor word matches its control state once the state has been quiet for SETTLE cycles. Only the bench's scenarios show that a monitor does not update early, that read-back values match software's view, that identifiers map to the right word and bit, and that unmapped or misaligned accesses read 0 and write nothing. These are shown with directed corner cases and a seeded random mix of writes.

// File: rtl/mgc_pkg.sv
package mgc_pkg;

  localparam int unsigned CTRL_BITS = 16;

  localparam logic [31:0] CLK_CTRL_BASE = 32'h0000_0600;
  localparam logic [31:0] CLK_MON_BASE  = 32'h0000_0800;
  localparam logic [31:0] RST_CTRL_BASE = 32'h0000_0900;
  localparam logic [31:0] RST_MON_BASE  = 32'h0000_0A00;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_CLK_CTRL,
    RG_CLK_MON,
    RG_RST_CTRL,
    RG_RST_MON
  } region_e;

  // True when address a is an aligned word inside a window of n words at base.
  function automatic logic in_window(logic [31:0] a, logic [31:0] base, int unsigned n);
    logic [31:0] top_addr;
    top_addr = base + 32'(4 * n);
    return (a[1:0] == 2'b00) && (a >= base) && (a < top_addr);
  endfunction

endpackage

// File: rtl/mgc_decode.sv
module mgc_decode
  import mgc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx
);

  logic [31:0] addr_ext;
  logic [31:0] base_sel;

  assign addr_ext = 32'(addr);

  always_comb begin
    region   = RG_NONE;
    base_sel = 32'h0;
    if (in_window(addr_ext, CLK_CTRL_BASE, NUM_WORDS)) begin
      region   = RG_CLK_CTRL;
      base_sel = CLK_CTRL_BASE;
    end else if (in_window(addr_ext, CLK_MON_BASE, NUM_WORDS)) begin
      region   = RG_CLK_MON;
      base_sel = CLK_MON_BASE;
    end else if (in_window(addr_ext, RST_CTRL_BASE, NUM_WORDS)) begin
      region   = RG_RST_CTRL;
      base_sel = RST_CTRL_BASE;
    end else if (in_window(addr_ext, RST_MON_BASE, NUM_WORDS)) begin
      region   = RG_RST_MON;
      base_sel = RST_MON_BASE;
    end
    idx = IDX_W'((addr_ext - base_sel) >> 2);
  end

endmodule

// File: rtl/mgc_ctrl_word.sv
module mgc_ctrl_word #(
  parameter int unsigned  CB      = 16,
  parameter logic [CB-1:0] RST_VAL = '0,
  parameter bit           INVERT  = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2*CB-1:0] wdata,
  output logic [CB-1:0] q
);

  logic [CB-1:0] val;
  logic [CB-1:0] mask;

  assign mask = wdata[2*CB-1:CB];

  generate
    if (INVERT) begin : g_inv
      assign val = ~wdata[CB-1:0];
    end else begin : g_dir
      assign val = wdata[CB-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (wr_en) begin
      q <= (q & ~mask) | (val & mask);
    end
  end

endmodule

// File: rtl/mgc_settle.sv
module mgc_settle #(
  parameter int unsigned  W       = 16,
  parameter int unsigned  DEPTH   = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(DEPTH); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/modgate_ctrl.sv
module modgate_ctrl
  import mgc_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SETTLE    = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_we,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  output logic [CTRL_BITS*NUM_WORDS-1:0] clk_en_o,
  output logic [CTRL_BITS*NUM_WORDS-1:0] rst_o
);

  localparam int unsigned CB    = CTRL_BITS;
  localparam int unsigned NB    = CB * NUM_WORDS;
  localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  region_e          region;
  logic [IDX_W-1:0] idx;

  logic [CB-1:0] clk_q   [NUM_WORDS];
  logic [CB-1:0] rst_q   [NUM_WORDS];
  logic [CB-1:0] clk_mon [NUM_WORDS];
  logic [CB-1:0] rst_mon [NUM_WORDS];

  logic [NB-1:0] clk_mon_flat;
  logic [NB-1:0] rst_mon_flat;

  mgc_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_WORDS(NUM_WORDS),
    .IDX_W    (IDX_W)
  ) u_decode (
    .addr  (bus_addr),
    .region(region),
    .idx   (idx)
  );

  for (genvar w = 0; w < int'(NUM_WORDS); w++) begin : g_word
    logic wr_clk;
    logic wr_rst;

    assign wr_clk = bus_we && (region == RG_CLK_CTRL) && (idx == IDX_W'(w));
    assign wr_rst = bus_we && (region == RG_RST_CTRL) && (idx == IDX_W'(w));

    mgc_ctrl_word #(
      .CB     (CB),
      .RST_VAL('0),
      .INVERT (1'b0)
    ) u_clk_word (
      .clk  (clk),
      .rst  (rst),
      .wr_en(wr_clk),
      .wdata(bus_wdata),
      .q    (clk_q[w])
    );

    // Reset word stores "in reset" per line; a data 1 releases it.
    mgc_ctrl_word #(
      .CB     (CB),
      .RST_VAL('1),
      .INVERT (1'b1)
    ) u_rst_word (
      .clk  (clk),
      .rst  (rst),
      .wr_en(wr_rst),
      .wdata(bus_wdata),
      .q    (rst_q[w])
    );

    mgc_settle #(
      .W      (CB),
      .DEPTH  (SETTLE),
      .RST_VAL('0)
    ) u_clk_settle (
      .clk(clk),
      .rst(rst),
      .d  (clk_q[w]),
      .q  (clk_mon[w])
    );

    mgc_settle #(
      .W      (CB),
      .DEPTH  (SETTLE),
      .RST_VAL('1)
    ) u_rst_settle (
      .clk(clk),
      .rst(rst),
      .d  (rst_q[w]),
      .q  (rst_mon[w])
    );

    assign clk_en_o[w*CB +: CB]     = clk_q[w];
    assign rst_o[w*CB +: CB]        = rst_q[w];
    assign clk_mon_flat[w*CB +: CB] = clk_mon[w];
    assign rst_mon_flat[w*CB +: CB] = rst_mon[w];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 32'h0;
    end else begin
      unique case (region)
        RG_CLK_CTRL: bus_rdata <= {16'h0, clk_q[idx]};
        RG_RST_CTRL: bus_rdata <= {16'h0, ~rst_q[idx]};
        RG_CLK_MON:  bus_rdata <= {16'h0, clk_mon_flat[idx*CB +: CB]};
        RG_RST_MON:  bus_rdata <= {16'h0, rst_mon_flat[idx*CB +: CB]};
        default:     bus_rdata <= 32'h0;
      endcase
    end
  end

endmodule

// File: rtl/modgate_ctrl_chk.sv
module modgate_ctrl_chk #(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SETTLE    = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_we,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [31:0]           bus_wdata,
  input logic [31:0]           bus_rdata,
  input logic [16*NUM_WORDS-1:0] clk_en_o,
  input logic [16*NUM_WORDS-1:0] rst_o,
  input logic [16*NUM_WORDS-1:0] clk_mon,
  input logic [16*NUM_WORDS-1:0] rst_mon
);

  localparam int unsigned NB    = 16 * NUM_WORDS;
  localparam int unsigned CNT_W = $clog2(SETTLE + 2);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(SETTLE);

  // Quiet-time counters: cycles since each output vector last changed.
  logic [NB-1:0]    clk_prev, rst_prev;
  logic [CNT_W-1:0] clk_quiet, rst_quiet;
  logic             clk_chg, rst_chg;

  assign clk_chg = (clk_en_o != clk_prev);
  assign rst_chg = (rst_o != rst_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_prev  <= '0;
      rst_prev  <= '1;
      clk_quiet <= SAT;
      rst_quiet <= SAT;
    end else begin
      clk_prev  <= clk_en_o;
      rst_prev  <= rst_o;
      clk_quiet <= clk_chg ? CNT_W'(1) : ((clk_quiet < SAT) ? clk_quiet + 1'b1 : clk_quiet);
      rst_quiet <= rst_chg ? CNT_W'(1) : ((rst_quiet < SAT) ? rst_quiet + 1'b1 : rst_quiet);
    end
  end

  AST_CLK_MON_SETTLED: assert property (@(posedge clk) disable iff (rst)
    (!clk_chg && clk_quiet >= SAT) |-> (clk_mon == clk_en_o)); // R5

  AST_RST_MON_SETTLED: assert property (@(posedge clk) disable iff (rst)
    (!rst_chg && rst_quiet >= SAT) |-> (rst_mon == rst_o)); // R6

  AST_CLK_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(clk_en_o)); // R2

  AST_RST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(rst_o)); // R4

  for (genvar w = 0; w < int'(NUM_WORDS); w++) begin : g_w
    localparam logic [ADDR_W-1:0] A_CM = ADDR_W'(32'h800 + 4 * w);
    localparam logic [ADDR_W-1:0] A_RM = ADDR_W'(32'hA00 + 4 * w);
    localparam logic [ADDR_W-1:0] A_CC = ADDR_W'(32'h600 + 4 * w);
    localparam logic [ADDR_W-1:0] A_RC = ADDR_W'(32'h900 + 4 * w);

    AST_MON_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (bus_we && (bus_addr == A_CM || bus_addr == A_RM))
        |=> ($stable(clk_en_o) && $stable(rst_o))); // R8

    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (bus_addr == A_CC || bus_addr == A_RC) |=> (bus_rdata[31:16] == 16'h0)); // R7
  end

  for (genvar i = 0; i < int'(NB); i++) begin : g_bit
    localparam logic [ADDR_W-1:0] A_CC = ADDR_W'(32'h600 + 4 * (i / 16));
    localparam logic [ADDR_W-1:0] A_RC = ADDR_W'(32'h900 + 4 * (i / 16));
    localparam int unsigned K = i % 16;

    AST_CLK_MASKED: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == A_CC && !bus_wdata[K+16]) |=> $stable(clk_en_o[i])); // R2

    AST_CLK_SET: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == A_CC && bus_wdata[K+16]) |=> (clk_en_o[i] == $past(bus_wdata[K]))); // R3

    AST_RST_MASKED: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == A_RC && !bus_wdata[K+16]) |=> $stable(rst_o[i])); // R2

    AST_RST_SET: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == A_RC && bus_wdata[K+16]) |=> (rst_o[i] == !$past(bus_wdata[K]))); // R4
  end

endmodule

bind modgate_ctrl modgate_ctrl_chk #(
  .NUM_WORDS(NUM_WORDS),
  .ADDR_W   (ADDR_W),
  .SETTLE   (SETTLE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .clk_en_o (clk_en_o),
  .rst_o    (rst_o),
  .clk_mon  (clk_mon_flat),
  .rst_mon  (rst_mon_flat)
);

// File: tb/modgate_ctrl_bench.sv
module modgate_ctrl_bench;

  localparam int unsigned NUM_WORDS = 4;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned SETTLE    = 4;
  localparam int unsigned NB        = 16 * NUM_WORDS;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NB-1:0]     clk_en_o, rst_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [NB-1:0] m_clk = '0;   // expected clock enables
  logic [NB-1:0] m_rst = '1;   // expected reset outputs (1 = in reset)

  always #5 clk = ~clk;

  modgate_ctrl #(
    .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .SETTLE(SETTLE)
  ) u_modgate_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_en_o(clk_en_o), .rst_o(rst_o)
  );

  function automatic logic [15:0] masked(logic [15:0] old, logic [31:0] d, bit inv);
    logic [15:0] v;
    v = inv ? ~d[15:0] : d[15:0];
    return (old & ~d[31:16]) | (v & d[31:16]);
  endfunction

  function automatic logic [ADDR_W-1:0] adr(logic [31:0] base, int unsigned w);
    return ADDR_W'(base + 32'(4 * w));
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  // Apply a write to the model when it targets a control word.
  task automatic model_write(logic [ADDR_W-1:0] a, logic [31:0] d);
    for (int w = 0; w < int'(NUM_WORDS); w++) begin
      if (a == adr(32'h600, w)) m_clk[w*16 +: 16] = masked(m_clk[w*16 +: 16], d, 1'b0);
      if (a == adr(32'h900, w)) m_rst[w*16 +: 16] = masked(m_rst[w*16 +: 16], d, 1'b1);
    end
  endtask

  task automatic check_all_monitors(string tag);
    logic [31:0] r;
    for (int w = 0; w < int'(NUM_WORDS); w++) begin
      rd(adr(32'h800, w), r);
      chk({tag, " R5 clk mon"}, 64'(r), 64'({16'h0, m_clk[w*16 +: 16]}));
      rd(adr(32'hA00, w), r);
      chk({tag, " R6 rst mon"}, 64'(r), 64'({16'h0, m_rst[w*16 +: 16]}));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [NB-1:0] old_clk, old_rst;
    void'($urandom(32'h5EED_1234));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 clk_en", 64'(clk_en_o), 64'(0));
    chk("R1 rst_o", 64'(rst_o), {64{1'b1}});
    rd(adr(32'h800, 0), r); chk("R1 clk mon", 64'(r), 64'h0);
    rd(adr(32'hA00, 1), r); chk("R1 rst mon", 64'(r), 64'h0000_FFFF);
    rd(adr(32'h900, 2), r); chk("R1 rst ctrl", 64'(r), 64'h0);

    // R3: all on in word 0, then one bit off
    wr(adr(32'h600, 0), 32'hFFFF_FFFF); model_write(adr(32'h600, 0), 32'hFFFF_FFFF);
    chk("R3 all on", 64'(clk_en_o), 64'(m_clk));
    wr(adr(32'h600, 0), 32'h0001_0000); model_write(adr(32'h600, 0), 32'h0001_0000);
    chk("R3 bit0 off", 64'(clk_en_o), 64'h0000_0000_0000_FFFE);

    // R2: data without enables changes nothing
    wr(adr(32'h600, 0), 32'h0000_0001);
    chk("R2 no enable", 64'(clk_en_o), 64'h0000_0000_0000_FFFE);

    // R4 and R6: release line 1 of word 0, keep line 0 asserted
    repeat (SETTLE + 1) @(negedge clk);
    old_rst = m_rst;
    wr(adr(32'h900, 0), 32'h0003_0002); model_write(adr(32'h900, 0), 32'h0003_0002);
    chk("R4 release bit1", 64'(rst_o), {{62{1'b1}}, 2'b01});
    repeat (SETTLE - 1) @(negedge clk);
    rd(adr(32'hA00, 0), r); chk("R6 mon not early", 64'(r), 64'({16'h0, old_rst[15:0]}));
    rd(adr(32'hA00, 0), r); chk("R6 mon after settle", 64'(r), 64'h0000_FFFD);
    rd(adr(32'h900, 0), r); chk("R7 rst readback", 64'(r), 64'h0000_0002);

    // R9 and R5: identifier 21 is word 1, bit 5
    old_clk = m_clk;
    wr(adr(32'h600, 1), (32'h1 << 21) | (32'h1 << 5)); model_write(adr(32'h600, 1), (32'h1 << 21) | (32'h1 << 5));
    chk("R9 id21", 64'(clk_en_o), 64'(old_clk) | (64'h1 << 21));
    repeat (SETTLE - 1) @(negedge clk);
    rd(adr(32'h800, 1), r); chk("R5 mon not early", 64'(r), 64'h0);
    rd(adr(32'h800, 1), r); chk("R5 mon after settle", 64'(r), 64'h0000_0020);
    rd(adr(32'h600, 1), r); chk("R7 clk readback", 64'(r), 64'h0000_0020);

    // R8: monitor, misaligned and unmapped writes are ignored
    wr(adr(32'h800, 0), 32'hFFFF_0000);
    wr(adr(32'hA00, 0), 32'hFFFF_FFFF);
    wr(ADDR_W'(32'h602), 32'hFFFF_0000);
    wr(ADDR_W'(32'h902), 32'hFFFF_FFFF);
    wr(adr(32'h600, NUM_WORDS), 32'hFFFF_FFFF);
    chk("R8 clk unchanged", 64'(clk_en_o), 64'(m_clk));
    chk("R8 rst unchanged", 64'(rst_o), 64'(m_rst));
    repeat (SETTLE + 1) @(negedge clk);
    check_all_monitors("R8");

    // R10: unmapped reads
    rd(ADDR_W'(32'h700), r); chk("R10 gap read", 64'(r), 64'h0);
    rd(adr(32'h900, NUM_WORDS), r); chk("R10 past end", 64'(r), 64'h0);
    rd(ADDR_W'(32'h601), r); chk("R10 misaligned", 64'(r), 64'h0);

    // Seeded random mix
    for (int it = 0; it < 300; it++) begin
      int unsigned kind, w;
      logic [31:0] d;
      logic [ADDR_W-1:0] a;
      kind = $urandom % 6;
      w = $urandom % NUM_WORDS;
      d = $urandom;
      case (kind)
        0, 1: a = adr(32'h600, w);
        2, 3: a = adr(32'h900, w);
        4: a = ($urandom % 2) ? adr(32'h800, w) : adr(32'hA00, w);
        default: a = ($urandom % 2) ? adr(32'h600, NUM_WORDS) : ADDR_W'(32'h904 + 32'($urandom % 2));
      endcase
      wr(a, d);
      model_write(a, d);
      chk("R2 R3 random clk", 64'(clk_en_o), 64'(m_clk));
      chk("R2 R4 random rst", 64'(rst_o), 64'(m_rst));
      rd(adr(32'h600, w), r); chk("R7 random clk rb", 64'(r), 64'({16'h0, m_clk[w*16 +: 16]}));
      rd(adr(32'h900, w), r); chk("R7 random rst rb", 64'(r), 64'({16'h0, ~m_rst[w*16 +: 16]}));
      if (it % 25 == 24) begin
        repeat (SETTLE + 1) @(negedge clk);
        check_all_monitors("random");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule